// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column addresses of one burst access to a synchronous DRAM. A start pulse captures a start column, a burst length code and a wrap-order bit. From the next clock onward the block presents one column address per cycle, together with a valid flag and a flag that marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size, in either sequential or interleaved order. A full-page burst steps through every column of the row and wraps at the page end. It runs until a terminate pulse stops it, which is how a precharge that cuts a burst short is modelled.

The column width is a parameter: 8 bits suits a x16 organisation, 9 a x8 and 10 a x4. A new burst may begin straight after the final beat of the previous one, so the block supports random column access with no idle cycles.

Top module: `burst_colgen`

## Requirements
- R1: A synchronous active-low reset forces `col_valid` and `col_last` low and `col_addr` to zero on the next clock edge. This holds even in the middle of a burst.
- R2: A `start` accepted while idle makes beat 0 appear on the next cycle with `col_valid` high and `col_addr` equal to `start_col`. After that, one beat is issued per cycle.
- R3: `burst_len` codes 0, 1, 2 and 3 give fixed bursts of 1, 2, 4 and 8 beats. Codes 4 to 7 select a full-page burst.
- R4: In a fixed burst with `interleave`=0, beat k has low log2(BL) bits equal to (start low bits + k) mod BL. The upper bits stay equal to those of `start_col`.
- R5: In a fixed burst with `interleave`=1, beat k has low log2(BL) bits equal to (start low bits XOR k). The upper bits are held.
- R6: `col_last` is high exactly on the final beat of a fixed burst. `col_valid` falls on the following cycle unless a new burst starts.
- R7: A full-page burst adds one to the column each cycle and wraps from the all-ones column to 0. It ignores `interleave`, never raises `col_last`, and continues until terminated.
- R8: `terminate` forces `col_valid` low on the next cycle. If `start` is high in the same cycle as `terminate`, the start is ignored.
- R9: A `start` that arrives while a burst is active and not on its final beat is ignored. The running burst continues unchanged.
- R10: A `start` that arrives on the cycle where `col_last` is high is accepted. Its beat 0 follows directly on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a burst with the values below |
| start_col | input | COL_W | First column of the burst |
| burst_len | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 4..7 give full page |
| interleave | input | 1 | 1 selects interleaved wrap order, 0 sequential |
| terminate | input | 1 | Stop the current burst at once |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | `col_addr` holds a beat of an active burst |
| col_last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Fixed bursts of every length are started at columns whose low bits are nonzero and, in one case, all ones. Run in both wrap orders, these show whether wrapping stays inside the aligned block, and the cases where the sequential and interleaved orders diverge tell the two orders apart. A full-page burst is started three columns below the page end with the interleave bit set, which exposes a wrap that fails at the page boundary or a full page that wrongly honours the wrap order. Starts arriving mid-burst, on the final beat and together with a terminate separate the ignore, back-to-back and terminate-priority rules, and a reset in mid-burst confirms that the state is cleared.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
    // log2 of a fixed burst length (0..3 -> 1..8 beats)
    typedef logic [1:0] blen_lg_t;
    localparam int MAX_LG = 3;
    localparam int CODE_W = 3;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_colgen_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output blen_lg_t          lg,
    output logic              full
);
    always_comb begin
        full = code[CODE_W-1];
        lg   = code[1:0];
    end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  blen_lg_t         lg,
    input  logic             il,
    input  logic             full,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] xr;

    always_comb begin
        sum = base + beat;
        xr  = base ^ beat;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < MAX_LG) begin : g_low
            logic in_blk;
            always_comb begin
                in_blk = int'(lg) > i;
                if (full)
                    col[i] = sum[i];
                else if (in_blk)
                    col[i] = il ? xr[i] : sum[i];
                else
                    col[i] = base[i];
            end
        end else begin : g_high
            always_comb col[i] = full ? sum[i] : base[i];
        end
    end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [COL_W-1:0]     start_col,
    input  logic [CODE_W-1:0]    burst_len,
    input  logic                 interleave,
    input  logic                 terminate,
    output logic [COL_W-1:0]     col_addr,
    output logic                 col_valid,
    output logic                 col_last
);
    typedef struct packed {
        logic             valid;
        logic             last;
        logic             full;
        logic             il;
        blen_lg_t         lg;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] addr;
    } state_t;

    state_t st_d, st_q;

    blen_lg_t         in_lg;
    logic             in_full;
    logic [COL_W-1:0] nxt_beat;
    logic [COL_W-1:0] nxt_col;
    logic [COL_W-1:0] fin_beat;
    logic             accept;

    burst_len_decode u_dec (
        .code (burst_len),
        .lg   (in_lg),
        .full (in_full)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base (st_q.base),
        .beat (nxt_beat),
        .lg   (st_q.lg),
        .il   (st_q.il),
        .full (st_q.full),
        .col  (nxt_col)
    );

    always_comb begin
        nxt_beat = st_q.beat + 1'b1;
        fin_beat = (COL_W'(1) << st_q.lg) - 1'b1;
        accept   = start && !terminate && (!st_q.valid || st_q.last);
        st_d     = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (terminate) begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end else if (accept) begin
            st_d.valid = 1'b1;
            st_d.full  = in_full;
            st_d.il    = interleave;
            st_d.lg    = in_lg;
            st_d.base  = start_col;
            st_d.beat  = '0;
            st_d.addr  = start_col;
            st_d.last  = !in_full && (in_lg == '0);
        end else if (st_q.valid && !st_q.last) begin
            st_d.beat = nxt_beat;
            st_d.addr = nxt_col;
            st_d.last = !st_q.full && (nxt_beat == fin_beat);
        end else begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign col_addr  = st_q.addr;
    assign col_valid = st_q.valid;
    assign col_last  = st_q.last;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !col_valid && !col_last);

    // R6
    a_r6_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R6
    a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && !start |=> !col_valid);

    // R7
    a_r7_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && st_q.full |-> !col_last);

    // R7
    a_r7_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && st_q.full && !terminate
        |=> col_valid && (col_addr == COL_W'($past(col_addr) + 1'b1)));

    // R8
    a_r8_terminate_stops: assert property (@(posedge clk) disable iff (!rst_n)
        terminate |=> !col_valid);

    // R9
    a_r9_busy_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !col_last && !terminate |=> col_valid && $stable(st_q.base));
endmodule

// File: tb/burst_colgen_test.sv
module burst_colgen_test;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [COL_W-1:0] start_col;
    logic [2:0]       burst_len;
    logic             interleave;
    logic             terminate;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .burst_len(burst_len), .interleave(interleave), .terminate(terminate),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
    );

    typedef struct packed {
        logic [7:0] col;
        logic [2:0] code;
        logic       il;
        logic [3:0] nbeats;
        logic [7:0] final_col;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 3'd0, 1'b0, 4'd1, 8'h00},
        '{8'h37, 3'd1, 1'b0, 4'd2, 8'h36},
        '{8'h37, 3'd1, 1'b1, 4'd2, 8'h36},
        '{8'h5D, 3'd2, 1'b0, 4'd4, 8'h5C},
        '{8'h5D, 3'd2, 1'b1, 4'd4, 8'h5E},
        '{8'h95, 3'd3, 1'b0, 4'd8, 8'h94},
        '{8'h95, 3'd3, 1'b1, 4'd8, 8'h92},
        '{8'hFF, 3'd3, 1'b0, 4'd8, 8'hFE},
        '{8'hA4, 3'd3, 1'b1, 4'd8, 8'hA3}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] s, input int k,
                                         input int len, input bit il);
        int lo;
        int hi;
        hi = s - (s % len);
        lo = il ? ((s % len) ^ k) : (((s % len) + k) % len);
        return 8'(hi + lo);
    endfunction

    task automatic begin_burst(input logic [7:0] c, input logic [2:0] code, input bit il);
        start = 1'b1; start_col = c; burst_len = code; interleave = il;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; start_col = '0; burst_len = '0;
        interleave = 1'b0; terminate = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(col_valid), 0);
        chk("R1 reset last", 32'(col_last), 0);
        chk("R1 reset addr", 32'(col_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            int len;
            len = 1 << VECS[v].code;
            begin_burst(VECS[v].col, VECS[v].code, VECS[v].il);
            for (int k = 0; k < len; k++) begin
                chk($sformatf("R2 vec%0d beat%0d valid", v, k), 32'(col_valid), 1);
                chk($sformatf("R4/R5 vec%0d beat%0d addr", v, k), 32'(col_addr),
                    32'(model(VECS[v].col, k, len, VECS[v].il)));
                chk($sformatf("R6 vec%0d beat%0d last", v, k), 32'(col_last),
                    32'(k == len - 1));
                if (k == len - 1) begin
                    chk($sformatf("R3 vec%0d count", v), 32'(k + 1), 32'(VECS[v].nbeats));
                    chk($sformatf("R4/R5 vec%0d final", v), 32'(col_addr),
                        32'(VECS[v].final_col));
                end
                @(negedge clk);
            end
            chk($sformatf("R6 vec%0d ends", v), 32'(col_valid), 0);
        end

        // R7 full page wraps, ignores interleave; R8 terminate beats start
        begin_burst(8'hFD, 3'd5, 1'b1);
        for (int k = 0; k < 6; k++) begin
            chk($sformatf("R7 full beat%0d addr", k), 32'(col_addr), 32'(8'(8'hFD + k)));
            chk($sformatf("R7 full beat%0d last", k), 32'(col_last), 0);
            chk($sformatf("R7 full beat%0d valid", k), 32'(col_valid), 1);
            if (k < 5) @(negedge clk);
        end
        terminate = 1'b1; start = 1'b1; start_col = 8'h40; burst_len = 3'd0;
        @(negedge clk);
        terminate = 1'b0; start = 1'b0;
        chk("R8 terminate stops", 32'(col_valid), 0);
        @(negedge clk);
        chk("R8 start with terminate ignored", 32'(col_valid), 0);

        // R9 start mid-burst ignored
        begin_burst(8'h10, 3'd3, 1'b0);
        for (int k = 0; k < 8; k++) begin
            if (k == 1) begin
                start = 1'b1; start_col = 8'h50; burst_len = 3'd0; interleave = 1'b1;
            end else begin
                start = 1'b0;
            end
            chk($sformatf("R9 beat%0d addr", k), 32'(col_addr), 32'(8'h10 + k));
            chk($sformatf("R9 beat%0d last", k), 32'(col_last), 32'(k == 7));
            @(negedge clk);
        end
        chk("R9 ends", 32'(col_valid), 0);

        // R10 back-to-back start on last beat
        begin_burst(8'h20, 3'd1, 1'b0);
        chk("R10 first beat", 32'(col_addr), 32'h20);
        @(negedge clk);
        chk("R10 last flagged", 32'(col_last), 1);
        start = 1'b1; start_col = 8'h33; burst_len = 3'd2; interleave = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R10 next beat%0d valid", k), 32'(col_valid), 1);
            chk($sformatf("R10 next beat%0d addr", k), 32'(col_addr), 32'(8'h33 ^ k));
            @(negedge clk);
        end

        // R1 reset mid-burst
        begin_burst(8'h80, 3'd3, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 midburst valid", 32'(col_valid), 0);
        chk("R1 midburst last", 32'(col_last), 0);
        chk("R1 midburst addr", 32'(col_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stays idle", 32'(col_valid), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule